// File: doc/BRIEF.md
# Weighted Block-Averaging Decimator

This block turns a fast stream of narrow signed samples, such as the output of a displacement filter running near 10 kHz with 10-bit words, into a slow stream of wide results, typically 50 per second at 24 bits. Each valid sample is scaled by an unsigned weight and summed into a wide signed accumulator.

A separate timing source supplies a periodic interval pulse. On each pulse the block closes the current block. It scales the running sum down by a right shift, clamps the result to a 24-bit signed word and presents it with a one-cycle valid strobe. It then starts the next block from zero.

The weight and the shift are plain inputs. The weight is applied to each sample as it arrives. The shift is applied at the moment a block closes.

Top module: `block_avg_decim`

## Requirements
- R1: While reset (`rstN` low) is asserted and after its release, `resultValid` is 0 and `resultOut` is 0 until the first interval pulse.
- R2: Every cycle with `sampleValid` high adds the product of `sampleIn` (two's complement) and `weight` (unsigned) to the block sum. Cycles with `sampleValid` low add nothing.
- R3: A cycle with `intervalPulse` high causes, on the next clock edge, `resultOut` to equal the block sum arithmetically shifted right by `shiftAmt` (0 to 15). `resultValid` is high for exactly that one cycle per pulse.
- R4: A valid sample in the same cycle as an interval pulse belongs to the block that is closing.
- R5: After a pulse the sum restarts from zero, so no sample contributes to two results.
- R6: An interval containing no valid samples produces a result of 0.
- R7: The shifted sum is clamped to the 24-bit signed range: above 8388607 gives 8388607, and below -8388608 gives -8388608.
- R8: Between results, `resultOut` holds its last value and `resultValid` stays 0, whatever samples arrive.
- R9: A sample given with weight 0 has no effect on the result.
- R10: The right shift rounds toward negative infinity, so a sum of -3 shifted by 1 gives -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 10 | Signed input sample |
| sampleValid | input | 1 | Qualifies `sampleIn` for one cycle |
| weight | input | 8 | Unsigned weight applied to the current sample |
| intervalPulse | input | 1 | Closes the current block |
| shiftAmt | input | 4 | Right-shift amount used when a block closes |
| resultOut | output | 24 | Signed, clamped block result |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
The internal sum is visible only through the next result. A sum that fails to clear, picks up a sample in the wrong cycle or misses a weighted product therefore shows up as a wrong `resultOut` exactly one cycle after the following interval pulse.

Short blocks with mixed signs, empty blocks, a sample that coincides with a pulse, and a zero weight each isolate one of these faults. Long runs of full-scale samples reach the clamp and the largest shift.

A control fault, such as a valid strobe that is missing, late or repeated, shows up within one cycle of the pulse.

// File: rtl/decim_pkg.sv
package decim_pkg;
  // Strobes handed from the control half to the datapath half
  typedef struct packed {
    logic addEn;    // fold the current weighted sample into the sum
    logic closeEn;  // latch a result and restart the sum
  } decimStrobes_t;
endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl
  import decim_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic          intervalPulse,
  output decimStrobes_t strobes,
  output logic          resultValid
);
  always_comb begin
    strobes.addEn   = sampleValid;
    strobes.closeEn = intervalPulse;
  end

  // Valid follows a close by one edge, for exactly one cycle
  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= intervalPulse;
  end
endmodule

// File: rtl/decim_datapath.sv
module decim_datapath
  import decim_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WEIGHT_W = 8,
  parameter int ACC_W    = 32,
  parameter int OUT_W    = 24,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  decimStrobes_t              strobes,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic        [WEIGHT_W-1:0] weight,
  input  logic        [SHIFT_W-1:0]  shiftAmt,
  output logic signed [OUT_W-1:0]    resultOut
);
  localparam int PROD_W = SAMPLE_W + WEIGHT_W + 1;
  localparam int EXT_W  = ACC_W - PROD_W;
  localparam logic signed [ACC_W-1:0] MAX_V = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MIN_V = ~MAX_V;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt;
  logic signed [ACC_W-1:0]  accReg;
  logic signed [ACC_W-1:0]  sumNow;
  logic signed [ACC_W-1:0]  shifted;
  logic signed [OUT_W-1:0]  clamped;

  always_comb begin
    // Zero-extended weight keeps it non-negative in a signed multiply
    prod    = sampleIn * $signed({1'b0, weight});
    prodExt = {{EXT_W{prod[PROD_W-1]}}, prod};
    sumNow  = accReg + (strobes.addEn ? prodExt : '0);
    shifted = sumNow >>> shiftAmt;
    if (shifted > MAX_V)      clamped = MAX_V[OUT_W-1:0];
    else if (shifted < MIN_V) clamped = MIN_V[OUT_W-1:0];
    else                      clamped = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg    <= '0;
      resultOut <= '0;
    end else if (strobes.closeEn) begin
      accReg    <= '0;
      resultOut <= clamped;
    end else if (strobes.addEn) begin
      accReg    <= sumNow;
    end
  end
endmodule

// File: rtl/block_avg_decim.sv
module block_avg_decim
  import decim_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WEIGHT_W = 8,
  parameter int ACC_W    = 32,
  parameter int OUT_W    = 24,
  parameter int SHIFT_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic        [WEIGHT_W-1:0] weight,
  input  logic                       intervalPulse,
  input  logic        [SHIFT_W-1:0]  shiftAmt,
  output logic signed [OUT_W-1:0]    resultOut,
  output logic                       resultValid
);
  decimStrobes_t strobes;

  decim_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .intervalPulse(intervalPulse),
    .strobes      (strobes),
    .resultValid  (resultValid)
  );

  decim_datapath #(
    .SAMPLE_W(SAMPLE_W), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W),
    .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .sampleIn (sampleIn),
    .weight   (weight),
    .shiftAmt (shiftAmt),
    .resultOut(resultOut)
  );
endmodule

// File: rtl/decim_checker.sv
module decim_checker #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             intervalPulse,
  input logic [OUT_W-1:0] resultOut,
  input logic             resultValid
);
  // R3: every pulse yields a strobe on the next edge
  assert_pulse_gives_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    intervalPulse |=> resultValid);

  // R8: no strobe without a preceding pulse
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !intervalPulse |=> !resultValid);

  // R8: the result only moves together with a strobe
  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(resultOut));

  // R6: back-to-back pulses with no sample between them give zero
  assert_empty_block_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intervalPulse && !sampleValid && $past(intervalPulse)) |=> (resultOut == '0));
endmodule

bind block_avg_decim decim_checker #(.OUT_W(OUT_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .sampleValid  (sampleValid),
  .intervalPulse(intervalPulse),
  .resultOut    (resultOut),
  .resultValid  (resultValid)
);

// File: tb/block_avg_decim_tb_top.sv
module block_avg_decim_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint MAXO = 8388607;
  localparam longint MINO = -8388608;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic signed [9:0] sampleIn = '0;
  logic              sampleValid = 1'b0;
  logic        [7:0] weight = '0;
  logic              intervalPulse = 1'b0;
  logic        [3:0] shiftAmt = '0;
  logic signed [23:0] resultOut;
  logic              resultValid;

  int compared = 0;
  int mismatched = 0;
  longint modelSum = 0;
  longint expQ[$];
  string  tagQ[$];
  bit     done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  block_avg_decim dut_i (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .weight(weight), .intervalPulse(intervalPulse), .shiftAmt(shiftAmt),
    .resultOut(resultOut), .resultValid(resultValid)
  );

  function automatic longint clampOut(longint v);
    if (v > MAXO) return MAXO;
    if (v < MINO) return MINO;
    return v;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drives one valid sample for one cycle
  task automatic sendSample(int s, int w);
    @(negedge clk);
    sampleIn = 10'(s); weight = 8'(w); sampleValid = 1'b1;
    modelSum += longint'(s) * longint'(w);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // Closes a block, optionally with a coinciding sample
  task automatic closeBlock(string tag, int sh, bit withSample, int s, int w);
    @(negedge clk);
    intervalPulse = 1'b1; shiftAmt = 4'(sh);
    if (withSample) begin
      sampleIn = 10'(s); weight = 8'(w); sampleValid = 1'b1;
      modelSum += longint'(s) * longint'(w);
    end
    expQ.push_back(clampOut(modelSum >>> sh));
    tagQ.push_back(tag);
    modelSum = 0;
    @(negedge clk);
    intervalPulse = 1'b0; sampleValid = 1'b0;
  endtask

  // Monitor: compare every strobed result against the scoreboard
  always @(negedge clk) begin
    if (rstN && resultValid) begin
      if (expQ.size() == 0) begin
        check("R8 unexpected strobe", 1, 0);
      end else begin
        check(tagQ.pop_front(), longint'(resultOut), expQ.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", longint'(resultValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 result after reset", longint'(resultOut), 0);
    check("R1 valid after reset", longint'(resultValid), 0);

    // R2 R3: mixed signs and weights, shift 2 -> 207 >>> 2 = 51
    sendSample(100, 3); sendSample(-20, 5); sendSample(7, 1);
    closeBlock("R2/R3 weighted sum", 2, 0, 0, 0);

    // R6 R5: empty interval right after a close
    closeBlock("R6 empty block", 0, 0, 0, 0);

    // R4: coinciding sample belongs to the closing block -> 20
    sendSample(10, 1);
    closeBlock("R4 coinciding sample", 0, 1, 5, 2);

    // R5: next block unaffected by the previous one -> 9
    sendSample(9, 1);
    closeBlock("R5 cleared sum", 0, 0, 0, 0);

    // R10: -3 >>> 1 = -2
    sendSample(-3, 1);
    closeBlock("R10 floor shift", 1, 0, 0, 0);

    // R9: weight 0 ignored -> 4
    sendSample(511, 0); sendSample(4, 1);
    closeBlock("R9 zero weight", 0, 0, 0, 0);

    // R8: samples without a pulse leave the output alone
    sendSample(200, 200); sendSample(-100, 9);
    check("R8 held result", longint'(resultOut), 4);
    check("R8 no strobe", longint'(resultValid), 0);
    closeBlock("R8 pending block", 3, 0, 0, 0);

    // R7: positive clamp
    for (int i = 0; i < 65; i++) sendSample(511, 255);
    closeBlock("R7 positive clamp", 0, 0, 0, 0);
    // R7: negative clamp
    for (int i = 0; i < 65; i++) sendSample(-512, 255);
    closeBlock("R7 negative clamp", 0, 0, 0, 0);
    // R3: same magnitude with largest shift -> 258
    for (int i = 0; i < 65; i++) sendSample(511, 255);
    closeBlock("R3 max shift", 15, 0, 0, 0);
    // R3: back-to-back pulses both strobe
    closeBlock("R3 back-to-back A", 0, 1, -7, 3);
    closeBlock("R3 back-to-back B", 0, 0, 0, 0);

    repeat (4) @(negedge clk);
    check("R3 all results seen", longint'(expQ.size()), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule